// File: doc/BRIEF.md
# Stage-Skipping Instruction Buffer with Selective Squash

This block sits in an in-order pipeline between an issuing stage N and a consuming stage N+2. Each instruction presented to it carries a thread identifier and a sequence number. On a skip query from stage N the block decides whether the instruction may jump directly into stage N+2, which it allows only when its own storage is empty and the downstream stage can take the instruction for that thread. Instructions that may not skip are inserted in the following stage and taken out again later, so the buffer keeps them in arrival order meanwhile.

The storage is a small array of slots that is always packed toward the head. The block supports appending at the tail (with refusal when full), deletion of the first entry matching a thread and sequence tag, discarding the head, a continuous view of the head entry, and a squash that deletes, out of order, every entry of one thread that is younger than a given sequence number. Every operation completes in one clock and answers with a done pulse in the next cycle. A counter records how many instructions took the skip path.

Top module: `stage_skip_buffer`

## Requirements
- R1: A skip query grants the skip (`sched_bypass`=1) only if the occupancy is 0 at the time of the query, `dn_blocked[sched_tid]` is 0 and `dn_free` is non-zero; in every other case the answer is 0 (queue path).
- R2: Each granted skip raises `bypass_count` by exactly one in the cycle its answer appears; a refused skip leaves the count unchanged.
- R3: An accepted insert places the entry at the tail, so entries leave in arrival order; `occupancy` always equals the number of valid slots and `head_valid` is 1 exactly when occupancy is non-zero.
- R4: An insert arriving when the occupancy (after any same-cycle deletions) equals DEPTH is refused with `ins_ok`=0 and leaves contents and occupancy unchanged; occupancy never exceeds DEPTH.
- R5: A remove deletes only the first (closest to head) valid entry whose thread and sequence number both equal the request; the other entries keep their relative order; a remove with no match changes nothing.
- R6: A pop discards the head entry (no effect when empty); `head_tid`/`head_seq` always show the oldest entry without removing it.
- R7: A squash deletes every entry whose thread equals `sq_tid` and whose sequence number is strictly greater than `sq_seq` (unsigned compare); entries of other threads and entries with a sequence number less than or equal to `sq_seq` stay in their original order.
- R8: Squash, remove and pop requested in the same cycle all act on the contents held at the start of that cycle; an insert in the same cycle is then judged against, and appended after, the reduced contents.
- R9: Each request (`sched_req`, `ins_req`, `rm_req`, `pop_req`, `sq_req`) produces a one-cycle done pulse on its own output in the cycle after the request.
- R10: While `rst_n` is 0 at a rising clock edge, all slots become invalid and the occupancy, the skip counter and all done outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sched_req | input | 1 | Skip query from stage N |
| sched_tid | input | TID_W | Thread of the queried instruction |
| dn_blocked | input | THREADS | Per-thread blocked flags of stage N+2 |
| dn_free | input | FREE_W | Free input slots of stage N+2 |
| sched_done | output | 1 | Skip answer valid |
| sched_bypass | output | 1 | 1: skip to N+2, 0: use the buffer |
| ins_req | input | 1 | Insert request |
| ins_tid | input | TID_W | Thread of inserted entry |
| ins_seq | input | SEQ_W | Sequence number of inserted entry |
| ins_done | output | 1 | Insert completed |
| ins_ok | output | 1 | Insert accepted (0: refused, full) |
| rm_req | input | 1 | Tagged remove request |
| rm_tid | input | TID_W | Thread tag to remove |
| rm_seq | input | SEQ_W | Sequence tag to remove |
| rm_done | output | 1 | Remove completed |
| pop_req | input | 1 | Discard head request |
| pop_done | output | 1 | Pop completed |
| sq_req | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Squash point; younger entries go |
| sq_done | output | 1 | Squash completed |
| head_valid | output | 1 | Head entry present |
| head_tid | output | TID_W | Thread of oldest entry |
| head_seq | output | SEQ_W | Sequence number of oldest entry |
| occupancy | output | OCC_W | Number of valid entries |
| bypass_count | output | BYP_W | Number of granted skips |

## Verification
On every cycle the assertions hold the occupancy within DEPTH and equal to the valid-slot count, refuse the skip whenever the buffer was not empty, tie each granted skip to a single counter step, refuse a lone insert into a full buffer and shrink the occupancy by one on a lone pop. Which entry a remove or squash deletes, that the survivors keep their order, the strict comparison at the squash point and the squash-before-insert rule in one cycle can only be shown by the bench's scenarios, which walk the head through the surviving entries and compare them against a queue model.

// File: rtl/ssb_pkg.sv
// Package: shared types for the stage-skipping buffer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package ssb_pkg;

    // Outcome of the skip query, held for one cycle after the request.
    typedef enum logic [1:0] {
        SKIP_IDLE    = 2'd0,
        SKIP_QUEUED  = 2'd1,
        SKIP_GRANTED = 2'd2
    } skip_res_e;

endpackage

// File: rtl/ssb_select.sv
// Module: ssb_select
// Decides, per slot, whether the entry survives this cycle. Squash, tagged
// remove and pop all look at the contents held at the start of the cycle.
// Assumes valid slots are packed toward index 0 (slot 0 is the head).
module ssb_select #(
    parameter int DEPTH = 4,
    parameter int TID_W = 1,
    parameter int SEQ_W = 8
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0][TID_W-1:0] tid,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq,
    input  logic                        sq_req,
    input  logic [TID_W-1:0]            sq_tid,
    input  logic [SEQ_W-1:0]            sq_seq,
    input  logic                        rm_req,
    input  logic [TID_W-1:0]            rm_tid,
    input  logic [SEQ_W-1:0]            rm_seq,
    input  logic                        pop_req,
    output logic [DEPTH-1:0]            keep
);

    logic [DEPTH-1:0] sq_hit;
    logic [DEPTH-1:0] rm_match;
    logic [DEPTH-1:0] rm_first;

    // Per-slot squash and tag comparisons.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign sq_hit[g]   = sq_req && valid[g] && (tid[g] == sq_tid) && (seq[g] > sq_seq);
        assign rm_match[g] = rm_req && valid[g] && (tid[g] == rm_tid) && (seq[g] == rm_seq);
    end

    // Priority pick of the match closest to the head.
    always_comb begin
        logic found;
        found    = 1'b0;
        rm_first = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rm_match[i] && !found) begin
                rm_first[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    // Survivor mask: valid and not hit by any deletion.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            keep[i] = valid[i] && !sq_hit[i] && !rm_first[i] && !(pop_req && (i == 0));
        end
    end

endmodule

// File: rtl/ssb_compact.sv
// Module: ssb_compact
// Packs the surviving slots toward index 0 while keeping their order, and
// reports how many survived. Purely combinational.
module ssb_compact #(
    parameter int DEPTH = 4,
    parameter int TID_W = 1,
    parameter int SEQ_W = 8,
    parameter int OCC_W = 3
) (
    input  logic [DEPTH-1:0]            keep,
    input  logic [DEPTH-1:0][TID_W-1:0] in_tid,
    input  logic [DEPTH-1:0][SEQ_W-1:0] in_seq,
    output logic [DEPTH-1:0][TID_W-1:0] out_tid,
    output logic [DEPTH-1:0][SEQ_W-1:0] out_seq,
    output logic [OCC_W-1:0]            out_cnt
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    // Ordered gather of survivors into consecutive slots.
    always_comb begin
        logic [OCC_W-1:0] cnt;
        cnt     = '0;
        out_tid = '0;
        out_seq = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                out_tid[cnt[IW-1:0]] = in_tid[i];
                out_seq[cnt[IW-1:0]] = in_seq[i];
                cnt = cnt + 1'b1;
            end
        end
        out_cnt = cnt;
    end

endmodule

// File: rtl/ssb_skip_ctl.sv
// Module: ssb_skip_ctl
// Answers the skip query from stage N and counts granted skips.
// Assumes buf_empty reflects the registered occupancy of this cycle.
module ssb_skip_ctl
    import ssb_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int TID_W   = 1,
    parameter int FREE_W  = 2,
    parameter int BYP_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sched_req,
    input  logic [TID_W-1:0]   sched_tid,
    input  logic [THREADS-1:0] dn_blocked,
    input  logic [FREE_W-1:0]  dn_free,
    input  logic               buf_empty,
    output logic               sched_done,
    output logic               sched_bypass,
    output logic [BYP_W-1:0]   bypass_count
);

    skip_res_e  res_q;
    logic       grant;
    logic [BYP_W-1:0] cnt_q;

    // All three skip conditions must hold.
    assign grant = buf_empty && !dn_blocked[sched_tid] && (dn_free != '0);

    // Hold the answer for one cycle and bump the counter on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= SKIP_IDLE;
            cnt_q <= '0;
        end else begin
            if (!sched_req) begin
                res_q <= SKIP_IDLE;
            end else if (grant) begin
                res_q <= SKIP_GRANTED;
                cnt_q <= cnt_q + 1'b1;
            end else begin
                res_q <= SKIP_QUEUED;
            end
        end
    end

    assign sched_done   = (res_q != SKIP_IDLE);
    assign sched_bypass = (res_q == SKIP_GRANTED);
    assign bypass_count = cnt_q;

endmodule

// File: rtl/stage_skip_buffer.sv
// Module: stage_skip_buffer
// In-order instruction buffer between stage N and stage N+2 with a skip
// path, tail insert, tagged remove, head pop/peek and thread squash.
// Assumes DEPTH >= 2; sequence numbers compare unsigned without wrap.
module stage_skip_buffer #(
    parameter int DEPTH   = 4,
    parameter int THREADS = 2,
    parameter int SEQ_W   = 8,
    parameter int FREE_W  = 2,
    parameter int BYP_W   = 16,
    parameter int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1,
    parameter int OCC_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sched_req,
    input  logic [TID_W-1:0]   sched_tid,
    input  logic [THREADS-1:0] dn_blocked,
    input  logic [FREE_W-1:0]  dn_free,
    output logic               sched_done,
    output logic               sched_bypass,
    input  logic               ins_req,
    input  logic [TID_W-1:0]   ins_tid,
    input  logic [SEQ_W-1:0]   ins_seq,
    output logic               ins_done,
    output logic               ins_ok,
    input  logic               rm_req,
    input  logic [TID_W-1:0]   rm_tid,
    input  logic [SEQ_W-1:0]   rm_seq,
    output logic               rm_done,
    input  logic               pop_req,
    output logic               pop_done,
    input  logic               sq_req,
    input  logic [TID_W-1:0]   sq_tid,
    input  logic [SEQ_W-1:0]   sq_seq,
    output logic               sq_done,
    output logic               head_valid,
    output logic [TID_W-1:0]   head_tid,
    output logic [SEQ_W-1:0]   head_seq,
    output logic [OCC_W-1:0]   occupancy,
    output logic [BYP_W-1:0]   bypass_count
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [OCC_W-1:0] DEPTH_C = OCC_W'(DEPTH);

    logic [DEPTH-1:0]            valid_q;
    logic [DEPTH-1:0][TID_W-1:0] tid_q;
    logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
    logic [OCC_W-1:0]            occ_q;

    logic [DEPTH-1:0]            keep;
    logic [DEPTH-1:0][TID_W-1:0] c_tid;
    logic [DEPTH-1:0][SEQ_W-1:0] c_seq;
    logic [OCC_W-1:0]            c_cnt;

    logic [DEPTH-1:0]            n_valid;
    logic [DEPTH-1:0][TID_W-1:0] n_tid;
    logic [DEPTH-1:0][SEQ_W-1:0] n_seq;
    logic [OCC_W-1:0]            n_cnt;
    logic                        ins_fit;

    logic ins_done_q, ins_ok_q, rm_done_q, pop_done_q, sq_done_q;

    ssb_select #(
        .DEPTH (DEPTH),
        .TID_W (TID_W),
        .SEQ_W (SEQ_W)
    ) u_select (
        .valid   (valid_q),
        .tid     (tid_q),
        .seq     (seq_q),
        .sq_req  (sq_req),
        .sq_tid  (sq_tid),
        .sq_seq  (sq_seq),
        .rm_req  (rm_req),
        .rm_tid  (rm_tid),
        .rm_seq  (rm_seq),
        .pop_req (pop_req),
        .keep    (keep)
    );

    ssb_compact #(
        .DEPTH (DEPTH),
        .TID_W (TID_W),
        .SEQ_W (SEQ_W),
        .OCC_W (OCC_W)
    ) u_compact (
        .keep    (keep),
        .in_tid  (tid_q),
        .in_seq  (seq_q),
        .out_tid (c_tid),
        .out_seq (c_seq),
        .out_cnt (c_cnt)
    );

    ssb_skip_ctl #(
        .THREADS (THREADS),
        .TID_W   (TID_W),
        .FREE_W  (FREE_W),
        .BYP_W   (BYP_W)
    ) u_skip (
        .clk          (clk),
        .rst_n        (rst_n),
        .sched_req    (sched_req),
        .sched_tid    (sched_tid),
        .dn_blocked   (dn_blocked),
        .dn_free      (dn_free),
        .buf_empty    (occ_q == '0),
        .sched_done   (sched_done),
        .sched_bypass (sched_bypass),
        .bypass_count (bypass_count)
    );

    // Insert is judged against the contents left after this cycle's deletions.
    assign ins_fit = (c_cnt < DEPTH_C);

    // Append an accepted insert after the compacted survivors.
    always_comb begin
        n_tid = c_tid;
        n_seq = c_seq;
        n_cnt = c_cnt;
        if (ins_req && ins_fit) begin
            n_tid[c_cnt[IW-1:0]] = ins_tid;
            n_seq[c_cnt[IW-1:0]] = ins_seq;
            n_cnt = c_cnt + 1'b1;
        end
    end

    // Valid bits follow the packed occupancy.
    for (genvar g = 0; g < DEPTH; g++) begin : g_valid
        assign n_valid[g] = (OCC_W'(g) < n_cnt);
    end

    // Storage and occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tid_q   <= '0;
            seq_q   <= '0;
            occ_q   <= '0;
        end else begin
            valid_q <= n_valid;
            tid_q   <= n_tid;
            seq_q   <= n_seq;
            occ_q   <= n_cnt;
        end
    end

    // One-cycle done pulses for the buffer operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_done_q <= 1'b0;
            ins_ok_q   <= 1'b0;
            rm_done_q  <= 1'b0;
            pop_done_q <= 1'b0;
            sq_done_q  <= 1'b0;
        end else begin
            ins_done_q <= ins_req;
            ins_ok_q   <= ins_req && ins_fit;
            rm_done_q  <= rm_req;
            pop_done_q <= pop_req;
            sq_done_q  <= sq_req;
        end
    end

    assign ins_done   = ins_done_q;
    assign ins_ok     = ins_ok_q;
    assign rm_done    = rm_done_q;
    assign pop_done   = pop_done_q;
    assign sq_done    = sq_done_q;
    assign head_valid = valid_q[0];
    assign head_tid   = tid_q[0];
    assign head_seq   = seq_q[0];
    assign occupancy  = occ_q;

endmodule

// File: rtl/ssb_checker.sv
// Module: ssb_checker
// Cycle-by-cycle properties of stage_skip_buffer, bound to every instance.
module ssb_checker #(
    parameter int DEPTH = 4,
    parameter int OCC_W = 3,
    parameter int BYP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sched_req,
    input logic             sched_done,
    input logic             sched_bypass,
    input logic             ins_req,
    input logic             ins_done,
    input logic             ins_ok,
    input logic             rm_req,
    input logic             pop_req,
    input logic             pop_done,
    input logic             sq_req,
    input logic             head_valid,
    input logic [DEPTH-1:0] valid_vec,
    input logic [OCC_W-1:0] occupancy,
    input logic [BYP_W-1:0] bypass_count
);

    p_skip_needs_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_req && occupancy != '0) |=> (sched_done && !sched_bypass));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_done && sched_bypass) |-> (bypass_count == $past(bypass_count) + 1'b1));

    p_valid_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(valid_vec) == occupancy) && (head_valid == (occupancy != '0)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= OCC_W'(DEPTH));

    p_full_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !sq_req && !rm_req && !pop_req && occupancy == OCC_W'(DEPTH))
        |=> (ins_done && !ins_ok && occupancy == OCC_W'(DEPTH)));

    p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !ins_req && !sq_req && !rm_req && occupancy != '0)
        |=> (occupancy == $past(occupancy) - 1'b1));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && pop_req) |=> (ins_done && pop_done));

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sched_req) |=> !sched_done);

endmodule

bind stage_skip_buffer ssb_checker #(
    .DEPTH (DEPTH),
    .OCC_W (OCC_W),
    .BYP_W (BYP_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sched_req    (sched_req),
    .sched_done   (sched_done),
    .sched_bypass (sched_bypass),
    .ins_req      (ins_req),
    .ins_done     (ins_done),
    .ins_ok       (ins_ok),
    .rm_req       (rm_req),
    .pop_req      (pop_req),
    .pop_done     (pop_done),
    .sq_req       (sq_req),
    .head_valid   (head_valid),
    .valid_vec    (valid_q),
    .occupancy    (occupancy),
    .bypass_count (bypass_count)
);

// File: tb/stage_skip_buffer_tb.sv
module stage_skip_buffer_tb;

    localparam int CLK_P   = 10;
    localparam int DEPTH   = 4;
    localparam int THREADS = 2;
    localparam int SEQ_W   = 8;
    localparam int FREE_W  = 2;
    localparam int BYP_W   = 16;
    localparam int TID_W   = 1;
    localparam int OCC_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sched_req = 1'b0;
    logic [TID_W-1:0] sched_tid = '0;
    logic [THREADS-1:0] dn_blocked = '0;
    logic [FREE_W-1:0] dn_free = '0;
    logic sched_done, sched_bypass;
    logic ins_req = 1'b0;
    logic [TID_W-1:0] ins_tid = '0;
    logic [SEQ_W-1:0] ins_seq = '0;
    logic ins_done, ins_ok;
    logic rm_req = 1'b0;
    logic [TID_W-1:0] rm_tid = '0;
    logic [SEQ_W-1:0] rm_seq = '0;
    logic rm_done;
    logic pop_req = 1'b0;
    logic pop_done;
    logic sq_req = 1'b0;
    logic [TID_W-1:0] sq_tid = '0;
    logic [SEQ_W-1:0] sq_seq = '0;
    logic sq_done;
    logic head_valid;
    logic [TID_W-1:0] head_tid;
    logic [SEQ_W-1:0] head_seq;
    logic [OCC_W-1:0] occupancy;
    logic [BYP_W-1:0] bypass_count;

    always #(CLK_P/2) clk = ~clk;

    stage_skip_buffer #(
        .DEPTH (DEPTH), .THREADS (THREADS), .SEQ_W (SEQ_W),
        .FREE_W (FREE_W), .BYP_W (BYP_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .sched_req (sched_req), .sched_tid (sched_tid),
        .dn_blocked (dn_blocked), .dn_free (dn_free),
        .sched_done (sched_done), .sched_bypass (sched_bypass),
        .ins_req (ins_req), .ins_tid (ins_tid), .ins_seq (ins_seq),
        .ins_done (ins_done), .ins_ok (ins_ok),
        .rm_req (rm_req), .rm_tid (rm_tid), .rm_seq (rm_seq), .rm_done (rm_done),
        .pop_req (pop_req), .pop_done (pop_done),
        .sq_req (sq_req), .sq_tid (sq_tid), .sq_seq (sq_seq), .sq_done (sq_done),
        .head_valid (head_valid), .head_tid (head_tid), .head_seq (head_seq),
        .occupancy (occupancy), .bypass_count (bypass_count)
    );

    typedef struct { int tid; int seq; } ent_t;
    typedef struct {
        string tag;
        bit    e_sd, e_sb, e_id, e_ok, e_rd, e_pd, e_qd;
        int    e_occ, e_hv, e_ht, e_hs, e_bc;
    } exp_t;

    ent_t model[$];
    exp_t exp_q[$];
    int   mbyp = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    // Driver helper: record the expected outputs of the cycle being driven.
    task automatic issue(string tag, bit sd, bit sb, bit id, bit ok, bit rd, bit pd, bit qd);
        exp_t e;
        e.tag = tag; e.e_sd = sd; e.e_sb = sb; e.e_id = id; e.e_ok = ok;
        e.e_rd = rd; e.e_pd = pd; e.e_qd = qd;
        e.e_occ = model.size();
        e.e_hv = (model.size() != 0);
        e.e_ht = (model.size() != 0) ? model[0].tid : -1;
        e.e_hs = (model.size() != 0) ? model[0].seq : -1;
        e.e_bc = mbyp;
        exp_q.push_back(e);
        @(negedge clk);
        sched_req = 1'b0; ins_req = 1'b0; rm_req = 1'b0; pop_req = 1'b0; sq_req = 1'b0;
    endtask

    task automatic op_idle(string tag);
        issue(tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic op_sched(string tag, int tid, logic [THREADS-1:0] blk, int free);
        bit byp;
        byp = (model.size() == 0) && !blk[tid] && (free != 0);
        if (byp) mbyp++;
        sched_req = 1'b1; sched_tid = TID_W'(tid); dn_blocked = blk; dn_free = FREE_W'(free);
        issue(tag, 1, byp, 0, 0, 0, 0, 0);
    endtask

    // Model step shared by insert paths: append when room remains.
    function automatic bit model_ins(int tid, int seq);
        ent_t e;
        if (model.size() >= DEPTH) return 1'b0;
        e.tid = tid; e.seq = seq;
        model.push_back(e);
        return 1'b1;
    endfunction

    task automatic op_ins(string tag, int tid, int seq);
        bit ok;
        ok = model_ins(tid, seq);
        ins_req = 1'b1; ins_tid = TID_W'(tid); ins_seq = SEQ_W'(seq);
        issue(tag, 0, 0, 1, ok, 0, 0, 0);
    endtask

    task automatic op_rm(string tag, int tid, int seq);
        for (int i = 0; i < model.size(); i++) begin
            if (model[i].tid == tid && model[i].seq == seq) begin
                model.delete(i);
                break;
            end
        end
        rm_req = 1'b1; rm_tid = TID_W'(tid); rm_seq = SEQ_W'(seq);
        issue(tag, 0, 0, 0, 0, 1, 0, 0);
    endtask

    task automatic op_pop(string tag);
        if (model.size() != 0) void'(model.pop_front());
        pop_req = 1'b1;
        issue(tag, 0, 0, 0, 0, 0, 1, 0);
    endtask

    // Squash, optionally with an insert in the same cycle (squash first).
    task automatic op_squash(string tag, int tid, int seq, bit with_ins, int itid, int iseq);
        ent_t keep_q[$];
        bit ok;
        ok = 1'b0;
        foreach (model[i]) if (!(model[i].tid == tid && model[i].seq > seq)) keep_q.push_back(model[i]);
        model = keep_q;
        if (with_ins) begin
            ok = model_ins(itid, iseq);
            ins_req = 1'b1; ins_tid = TID_W'(itid); ins_seq = SEQ_W'(iseq);
        end
        sq_req = 1'b1; sq_tid = TID_W'(tid); sq_seq = SEQ_W'(seq);
        issue(tag, 0, 0, with_ins, ok, 0, 0, 1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        model.delete();
        mbyp = 0;
        rst_n = 1'b1;
    endtask

    // Monitor: compare each recorded expectation a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() != 0) begin
                exp_t e;
                bit bad;
                e = exp_q.pop_front();
                n_checks++;
                bad = (sched_done !== e.e_sd) || (e.e_sd && sched_bypass !== e.e_sb) ||
                      (ins_done !== e.e_id) || (e.e_id && ins_ok !== e.e_ok) ||
                      (rm_done !== e.e_rd) || (pop_done !== e.e_pd) || (sq_done !== e.e_qd) ||
                      (int'(occupancy) != e.e_occ) || (int'(head_valid) != e.e_hv) ||
                      (e.e_hv == 1 && (int'(head_tid) != e.e_ht || int'(head_seq) != e.e_hs)) ||
                      (int'(bypass_count) != e.e_bc);
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s: got sd=%0b sb=%0b id=%0b ok=%0b occ=%0d hv=%0b head=%0d/%0d bc=%0d ; exp sd=%0b sb=%0b id=%0b ok=%0b occ=%0d hv=%0d head=%0d/%0d bc=%0d",
                             e.tag, sched_done, sched_bypass, ins_done, ins_ok, occupancy, head_valid,
                             head_tid, head_seq, bypass_count, e.e_sd, e.e_sb, e.e_id, e.e_ok,
                             e.e_occ, e.e_hv, e.e_ht, e.e_hs, e.e_bc);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running, exp finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        @(negedge clk);
        do_reset();
        op_idle("R10 reset state empty");
        // R1/R2: skip conditions
        op_sched("R1 R2 empty and free: skip", 0, 2'b00, 1);
        op_sched("R1 thread blocked: queue", 1, 2'b10, 2);
        op_sched("R1 other thread blocked: skip", 0, 2'b10, 3);
        op_sched("R1 no free slot: queue", 0, 2'b00, 0);
        // R3: fill in order
        op_ins("R3 insert t0 s10", 0, 10);
        op_sched("R1 R2 nonempty: queue, count held", 0, 2'b00, 3);
        op_ins("R3 insert t1 s11", 1, 11);
        op_ins("R3 insert t0 s12", 0, 12);
        op_ins("R3 insert t1 s13", 1, 13);
        // R4: refuse when full
        op_ins("R4 full insert refused", 0, 14);
        op_idle("R4 contents unchanged after refusal");
        // R5: remove middle entry, then a miss
        op_rm("R5 remove t0 s12", 0, 12);
        op_rm("R5 remove miss (t1 s12)", 1, 12);
        // R6: walk head through survivors
        op_pop("R6 pop head s10");
        op_pop("R6 pop head s11");
        op_pop("R6 pop head s13");
        op_pop("R6 pop on empty");
        // R7: squash strictly younger of one thread
        op_ins("R7 fill t0 s20", 0, 20);
        op_ins("R7 fill t1 s21", 1, 21);
        op_ins("R7 fill t1 s22", 1, 22);
        op_ins("R7 fill t0 s23", 0, 23);
        op_squash("R7 squash t1 above 21", 1, 21, 0, 0, 0);
        op_pop("R7 survivor order s21");
        op_pop("R7 survivor order s23");
        // R8: squash and insert in one cycle on a full buffer
        op_ins("R8 fill t1 s30", 1, 30);
        op_ins("R8 fill t0 s31", 0, 31);
        op_ins("R8 fill t1 s32", 1, 32);
        op_squash("R8 squash t0 above 30 plus insert t1 s33", 0, 30, 1, 1, 33);
        op_pop("R8 order s30");
        op_pop("R8 order s32");
        op_pop("R8 inserted entry last s33");
        // R5: duplicate tags, only the first goes
        op_ins("R5 dup t0 s40 a", 0, 40);
        op_ins("R5 t1 s41", 1, 41);
        op_ins("R5 dup t0 s40 b", 0, 40);
        op_rm("R5 remove first of duplicates", 0, 40);
        op_pop("R5 next head t1 s41");
        // R10: reset mid-run
        op_sched("R2 queue while nonempty", 1, 2'b00, 1);
        do_reset();
        op_idle("R10 reset clears contents and counter");
        op_sched("R1 R2 skip after reset", 1, 2'b00, 1);
        op_idle("R9 done pulse falls");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule